// File: doc/BRIEF.md
# Byte-Lane Write SRAM Core with Registered Read

A small synchronous memory array of 256 words by 32 bits, organised as four 8-bit byte lanes. An external sequencer supplies a word address and a select flag each cycle. Three active-low write controls decide what a selected cycle does:

- a global write that stores the whole word;
- a byte-write enable that, together with one active-low select per lane, stores only the chosen lanes;
- when neither applies, the cycle reads.

Read data is registered. The word addressed at one rising edge is presented during the clock period that follows. An asynchronous, active-low output enable gates the read data. The tri-state driver is modelled by a valid flag and a data bus forced to zero while not driven. The first read after a deselected cycle does not drive the bus, even with output enable low. A read that directly follows a write to the same word returns the new data.

Top module: `byte_sram_core`

## Requirements
- R1: At a rising edge with sel_i high and gw_ni low, all four lanes of word addr_i take wdata_i, whatever bwe_ni and bsel_ni are.
- R2: At a rising edge with sel_i high, gw_ni high and bwe_ni low, lane k (bits 8k+7:8k, lane 0 = bits 7:0) is written exactly when bsel_ni[k] is low; the other lanes keep their contents.
- R3: A selected cycle with gw_ni high and either bwe_ni high or bsel_ni all ones writes nothing and is a read cycle.
- R4: A cycle with sel_i low writes nothing, whatever the write controls are.
- R5: After a read edge, rdata_o holds the word stored at the address sampled at that edge, for the whole following clock period.
- R6: While oe_ni is high, rvalid_o is low and rdata_o is zero. oe_ni acts combinationally, with no clock.
- R7: The clock period after a read edge that directly follows a deselected edge (or reset) has rvalid_o low, whatever oe_ni is. A read that directly follows another selected cycle is driven normally.
- R8: The clock period after a write edge or a deselected edge has rvalid_o low and rdata_o zero.
- R9: A read of a word in the cycle right after a write to it returns the newly written lanes merged with the unchanged ones.
- R10: While rst_ni is low, and until the first read edge after reset, rvalid_o is low and rdata_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Device selected for this cycle |
| addr_i | input | 8 | Word address |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte-write enable, active low |
| bsel_ni | input | 4 | Per-lane byte selects, active low, bit k = lane k |
| wdata_i | input | 32 | Write data |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| rdata_o | output | 32 | Read data, zero when not driven |
| rvalid_o | output | 1 | Read data is being driven |

## Verification
The bench builds the block with its default parameters: 8 address bits, four lanes and 8-bit lanes. With these values the bench can preload and then revisit every one of the 256 words. Every combination of the four byte selects is reachable in the random phase, so each single-lane and mixed-lane merge is checked against a bench-side word model. The default width also places the lane boundaries at fixed bit positions, so a lane that is misrouted or shifted shows up as a data mismatch.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  parameter int ADDR_W_DEF = 8;
  parameter int LANES_DEF  = 4;
  parameter int LANE_W_DEF = 8;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_e;
endpackage

// File: rtl/bsram_wr_decode.sv
module bsram_wr_decode
  import bsram_pkg::*;
#(
  parameter int LANES = LANES_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             gw_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] bsel_ni,
  output logic [LANES-1:0] lane_we_o,
  output cyc_kind_e        kind_o
);
  logic [LANES-1:0] byte_we;

  // global write overrides byte qualification
  always_comb begin
    byte_we = bwe_ni ? '0 : ~bsel_ni;
    if (!sel_i)      lane_we_o = '0;
    else if (!gw_ni) lane_we_o = '1;
    else             lane_we_o = byte_we;
  end

  always_comb begin
    if (!sel_i)           kind_o = CYC_IDLE;
    else if (|lane_we_o)  kind_o = CYC_WRITE;
    else                  kind_o = CYC_READ;
  end

  a_r4_desel_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |-> (lane_we_o == '0) && (kind_o == CYC_IDLE));

  a_r1_global_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_o == CYC_WRITE && !gw_ni) |-> &lane_we_o);
endmodule

// File: rtl/bsram_lane_array.sv
module bsram_lane_array
  import bsram_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int LANES  = LANES_DEF,
  parameter int LANE_W = LANE_W_DEF,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  lane_we_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_q_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (lane_we_i[g]) mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      rd_q <= '0;
      else if (rd_en_i) rd_q <= mem[addr_i];
    end

    assign rd_q_o[g*LANE_W +: LANE_W] = rd_q;
  end

  a_r3_read_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |-> (lane_we_i == '0));
endmodule

// File: rtl/bsram_out_stage.sv
module bsram_out_stage
  import bsram_pkg::*;
#(
  parameter int DATA_W = LANES_DEF * LANE_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cyc_kind_e         kind_i,
  input  logic              oe_ni,
  input  logic [DATA_W-1:0] rd_q_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic act_q, mask_q, desel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      mask_q  <= 1'b0;
      desel_q <= 1'b1;
    end else begin
      act_q   <= (kind_i == CYC_READ);
      mask_q  <= (kind_i == CYC_READ) && desel_q;
      desel_q <= (kind_i == CYC_IDLE);
    end
  end

  assign rvalid_o = act_q && !mask_q && !oe_ni;
  assign rdata_o  = rvalid_o ? rd_q_i : '0;

  a_r6_oe_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !rvalid_o && (rdata_o == '0));

  a_r8_no_drive_after_nonread: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i != CYC_READ) |=> !rvalid_o);

  a_r7_first_read_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(kind_i == CYC_IDLE) && kind_i == CYC_READ) |=> !rvalid_o);
endmodule

// File: rtl/byte_sram_core.sv
module byte_sram_core
  import bsram_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int LANES  = LANES_DEF,
  parameter int LANE_W = LANE_W_DEF,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              gw_ni,
  input  logic              bwe_ni,
  input  logic [LANES-1:0]  bsel_ni,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              oe_ni,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic [LANES-1:0]  lane_we;
  cyc_kind_e         kind;
  logic [DATA_W-1:0] rd_q;

  bsram_wr_decode #(.LANES(LANES)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel_i),
    .gw_ni     (gw_ni),
    .bwe_ni    (bwe_ni),
    .bsel_ni   (bsel_ni),
    .lane_we_o (lane_we),
    .kind_o    (kind)
  );

  bsram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .lane_we_i (lane_we),
    .rd_en_i   (kind == CYC_READ),
    .wdata_i   (wdata_i),
    .rd_q_o    (rd_q)
  );

  bsram_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kind_i   (kind),
    .oe_ni    (oe_ni),
    .rd_q_i   (rd_q),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );
endmodule

// File: tb/byte_sram_core_test.sv
module byte_sram_core_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        gw_ni = 1'b1;
  logic        bwe_ni = 1'b1;
  logic [3:0]  bsel_ni = 4'hf;
  logic [31:0] wdata_i = '0;
  logic        oe_ni = 1'b0;
  logic [31:0] rdata_o;
  logic        rvalid_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] model [256];
  logic        e_act = 1'b0, e_mask = 1'b0, e_desel = 1'b1;
  logic [31:0] e_rd = '0;

  always #5 clk = ~clk;

  byte_sram_core uut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel_i), .addr_i(addr_i),
    .gw_ni(gw_ni), .bwe_ni(bwe_ni), .bsel_ni(bsel_ni), .wdata_i(wdata_i),
    .oe_ni(oe_ni), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  function automatic logic [3:0] lanes_written(logic s, logic g, logic b, logic [3:0] bs);
    if (!s) return 4'h0;
    if (!g) return 4'hf;
    if (!b) return ~bs;
    return 4'h0;
  endfunction

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] we);
    logic [31:0] r = old;
    for (int k = 0; k < 4; k++) if (we[k]) r[k*8 +: 8] = nw[k*8 +: 8];
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act_d, logic [31:0] exp_d, logic act_v, logic exp_v);
    n_chk++;
    if (act_d !== exp_d || act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: rdata=%h rvalid=%b expected rdata=%h rvalid=%b", tag, act_d, act_v, exp_d, exp_v);
    end
  endtask

  // one clock: drive, edge, set oe for the next period, compare
  task automatic cyc(string tag, logic s, logic [7:0] a, logic g, logic b, logic [3:0] bs,
                     logic [31:0] wd, logic oe_after);
    logic [3:0] we;
    logic rd, ev;
    sel_i = s; addr_i = a; gw_ni = g; bwe_ni = b; bsel_ni = bs; wdata_i = wd;
    we = lanes_written(s, g, b, bs);
    rd = s && (we == 4'h0);
    @(posedge clk);
    if (rd) e_rd = model[a];
    model[a] = merge(model[a], wd, we);
    e_mask  = rd && e_desel;
    e_act   = rd;
    e_desel = !s;
    #1 oe_ni = oe_after;
    #1;
    ev = e_act && !e_mask && !oe_ni;
    check(tag, rdata_o, ev ? e_rd : 32'h0, rvalid_o, ev);
  endtask

  initial begin
    #200000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #2 check("R10 reset", rdata_o, 32'h0, rvalid_o, 1'b0);
    rst_ni = 1'b1;
    #2 check("R10 after release", rdata_o, 32'h0, rvalid_o, 1'b0);

    // preload every word with global write, byte controls scrambled (R1)
    for (int i = 0; i < 256; i++)
      cyc("R1 preload", 1'b1, 8'(i), 1'b0, 1'($urandom), 4'($urandom), $urandom, 1'b0);

    // R1 directly read back
    cyc("R1 gw write", 1'b1, 8'h10, 1'b0, 1'b1, 4'hf, 32'hdeadbeef, 1'b0);
    cyc("R9 read after write", 1'b1, 8'h10, 1'b1, 1'b1, 4'hf, 32'h0, 1'b0);
    check("R1 all lanes", rdata_o, 32'hdeadbeef, rvalid_o, 1'b1);

    // R2 partial write lanes 0 and 2, then R9 merge
    cyc("R2 byte write", 1'b1, 8'h10, 1'b1, 1'b0, 4'b1010, 32'h11223344, 1'b0);
    cyc("R9 merged read", 1'b1, 8'h10, 1'b1, 1'b1, 4'h0, 32'h0, 1'b0);
    check("R2 lanes 0,2 only", rdata_o, 32'hde22be44, rvalid_o, 1'b1);

    // R3 bwe low with no lanes selected is a read
    cyc("R3 bwe low all bsel high", 1'b1, 8'h10, 1'b1, 1'b0, 4'hf, 32'hffffffff, 1'b0);
    check("R3 no write, read", rdata_o, 32'hde22be44, rvalid_o, 1'b1);
    cyc("R3 follow-up read", 1'b1, 8'h10, 1'b1, 1'b1, 4'h0, 32'h12345678, 1'b0);

    // R4 deselected write, then first read masked (R7), second read valid
    cyc("R4 deselected write", 1'b0, 8'h10, 1'b0, 1'b0, 4'h0, 32'h0badf00d, 1'b0);
    cyc("R7 first read masked", 1'b1, 8'h10, 1'b1, 1'b1, 4'hf, 32'h0, 1'b0);
    check("R7 masked", rdata_o, 32'h0, rvalid_o, 1'b0);
    cyc("R4 unchanged", 1'b1, 8'h10, 1'b1, 1'b1, 4'hf, 32'h0, 1'b0);
    check("R4 word kept", rdata_o, 32'hde22be44, rvalid_o, 1'b1);

    // R6 oe high blocks, then oe low re-drives same data
    cyc("R6 oe high", 1'b1, 8'h10, 1'b1, 1'b1, 4'hf, 32'h0, 1'b1);
    check("R6 tristate", rdata_o, 32'h0, rvalid_o, 1'b0);
    #1 oe_ni = 1'b0; #1;
    check("R6 async re-enable", rdata_o, 32'hde22be44, rvalid_o, 1'b1);

    // R8 period after write shows nothing
    cyc("R8 after write", 1'b1, 8'h20, 1'b0, 1'b1, 4'hf, 32'hcafe0001, 1'b0);
    check("R8 idle bus", rdata_o, 32'h0, rvalid_o, 1'b0);

    // R5 read pipeline across distinct addresses
    cyc("R5 read a", 1'b1, 8'h20, 1'b1, 1'b1, 4'hf, 32'h0, 1'b0);
    cyc("R5 read b", 1'b1, 8'h10, 1'b1, 1'b1, 4'hf, 32'h0, 1'b0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic s, g, b, o;
      s = ($urandom % 8) != 0;
      g = ($urandom % 4) != 0;
      b = ($urandom % 2) != 0;
      o = ($urandom % 6) == 0;
      cyc("R5 random", s, 8'($urandom), g, b, 4'($urandom), $urandom, o);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule